// File: doc/BRIEF.md
# Sensor Change Interrupt Port

This block watches an 8-bit sensor value. It raises an interrupt request whenever that value differs from its previous sample. The raw input is captured in one register, and a second register keeps the sample before it. When the two disagree, a sticky request flag is set. The flag stays up until the processor pulses an acknowledge line, so one burst of activity gives one request rather than a stream of them.

The processor reads the most recent captured sample through a small bus slave port. That port acknowledges every strobed cycle in the same cycle, with no wait states. Write cycles are accepted but change nothing.

After reset the comparison stays disabled until both sample registers have been loaded. A sensor that already sits at a non-zero value when reset is released therefore raises no request.

Top module: `sensor_change_irq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `irq_req_o` is 0 and `rd_dat_o` is 0.
- R2: `rd_dat_o` equals the value `sense_i` held at the previous rising clock edge (one register stage).
- R3: `ack_o` is 1 in exactly the cycles where `cyc_i` and `stb_i` are both 1, combinationally, with no wait state.
- R4: A bus cycle with `we_i` = 1 changes neither `rd_dat_o` nor `irq_req_o`, whatever `wr_dat_i` carries.
- R5: When `sense_i` takes a new value before edge k, `irq_req_o` is still 0 after edge k and is 1 after edge k+1. An unchanged value never sets it.
- R6: Once set, `irq_req_o` stays 1 until acknowledged, even if the sensor stays constant or changes again.
- R7: A 1 on `irq_ack_i` at an edge clears `irq_req_o` after that edge when no change is pending in that cycle.
- R8: If a change is pending in the same cycle that `irq_ack_i` is 1, `irq_req_o` is 1 after the edge (set wins over clear).
- R9: A non-zero `sense_i` held steady through reset and after it produces no request once reset is released.
- R10: A flip of any single bit among the 8 sensor bits sets the request (all bit positions are compared).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Bus strobe for this port |
| we_i | input | 1 | Bus write enable (writes are ignored) |
| wr_dat_i | input | 8 | Bus write data (ignored) |
| ack_o | output | 1 | Bus acknowledge |
| rd_dat_o | output | 8 | Most recent captured sensor sample |
| sense_i | input | 8 | Raw sensor value |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_req_o | output | 1 | Sticky interrupt request |

## Verification
The hardest case to reach from the ports is a change that is pending in exactly the cycle where the acknowledge arrives. The change is only visible inside the block, one edge after the input moves. The bench counts edges from the moment it moves `sense_i` and raises `irq_ack_i` right after the first edge, so the two meet at the second edge. It also holds a non-zero sensor value through reset, to show that the priming logic suppresses the first comparison. It then sweeps a full permutation of all 256 values and every single-bit flip.

// File: rtl/sensirq_pkg.sv
package sensirq_pkg;

  // Next state of the sticky request: a detected change sets it, an
  // acknowledge clears it, and set takes priority over clear.
  function automatic logic req_next(input logic req, input logic chg, input logic clr);
    logic r;
    r = req;
    if (clr) r = 1'b0;
    if (chg) r = 1'b1;
    return r;
  endfunction

  // Bus acknowledge for a single-cycle slave.
  function automatic logic bus_ack(input logic cyc, input logic stb);
    return cyc & stb;
  endfunction

endpackage

// File: rtl/sensirq_sampler.sv
module sensirq_sampler #(
  parameter int unsigned SENSE_W = 8,
  parameter int unsigned PRIME_DEPTH = 2
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [SENSE_W-1:0] sense_i,
  output logic [SENSE_W-1:0] cur_o,
  output logic [SENSE_W-1:0] prev_o,
  output logic               chg_o
);

  localparam int unsigned PD = (PRIME_DEPTH < 2) ? 2 : PRIME_DEPTH;

  logic [SENSE_W-1:0] cur_q, prev_q;
  logic [PD-1:0]      prime_q;
  logic               primed;
  logic [SENSE_W-1:0] bit_diff;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cur_q   <= '0;
      prev_q  <= '0;
      prime_q <= '0;
    end else begin
      cur_q   <= sense_i;
      prev_q  <= cur_q;
      prime_q <= {prime_q[PD-2:0], 1'b1};
    end
  end

  // Per-bit comparison of the two stages.
  for (genvar b = 0; b < SENSE_W; b++) begin : g_cmp
    assign bit_diff[b] = cur_q[b] ^ prev_q[b];
  end

  assign primed = prime_q[PD-1];
  assign chg_o  = primed & (|bit_diff);
  assign cur_o  = cur_q;
  assign prev_o = prev_q;

  AST_CUR_TRACKS_INPUT: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> (cur_q == $past(sense_i)));  // R2

  AST_PREV_TRACKS_CUR: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> (prev_q == $past(cur_q)));  // R5

  AST_NO_CHG_UNPRIMED: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> !chg_o);  // R9

endmodule

// File: rtl/sensirq_flag.sv
module sensirq_flag
  import sensirq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic chg_i,
  input  logic clr_i,
  output logic req_o
);

  logic req_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) req_q <= 1'b0;
    else       req_q <= req_next(req_q, chg_i, clr_i);
  end

  assign req_o = req_q;

  AST_CHANGE_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
    chg_i |=> req_q);  // R5

  AST_REQ_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_q && !clr_i) |=> req_q);  // R6

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !chg_i) |=> !req_q);  // R7

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && chg_i) |=> req_q);  // R8

  AST_RISE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(req_q) |-> $past(chg_i));  // R5

endmodule

// File: rtl/sensirq_port.sv
module sensirq_port
  import sensirq_pkg::*;
#(
  parameter int unsigned SENSE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               cyc_i,
  input  logic               stb_i,
  input  logic               we_i,
  input  logic [SENSE_W-1:0] wr_dat_i,
  input  logic [SENSE_W-1:0] sample_i,
  output logic               ack_o,
  output logic [SENSE_W-1:0] rd_dat_o
);

  assign ack_o    = bus_ack(cyc_i, stb_i);
  assign rd_dat_o = sample_i;

  AST_ACK_NEEDS_CYC: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |-> (cyc_i && stb_i));  // R3

  AST_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && we_i && (wr_dat_i != sample_i)) |-> (rd_dat_o == sample_i));  // R4

endmodule

// File: rtl/sensor_change_irq.sv
module sensor_change_irq #(
  parameter int unsigned SENSE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               cyc_i,
  input  logic               stb_i,
  input  logic               we_i,
  input  logic [SENSE_W-1:0] wr_dat_i,
  output logic               ack_o,
  output logic [SENSE_W-1:0] rd_dat_o,
  input  logic [SENSE_W-1:0] sense_i,
  input  logic               irq_ack_i,
  output logic               irq_req_o
);

  logic [SENSE_W-1:0] cur_sample;
  logic [SENSE_W-1:0] prev_sample;
  logic               chg_evt;

  sensirq_sampler #(.SENSE_W(SENSE_W), .PRIME_DEPTH(2)) u_sampler (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .sense_i (sense_i),
    .cur_o   (cur_sample),
    .prev_o  (prev_sample),
    .chg_o   (chg_evt)
  );

  sensirq_flag u_flag (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .chg_i (chg_evt),
    .clr_i (irq_ack_i),
    .req_o (irq_req_o)
  );

  sensirq_port #(.SENSE_W(SENSE_W)) u_port (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cyc_i    (cyc_i),
    .stb_i    (stb_i),
    .we_i     (we_i),
    .wr_dat_i (wr_dat_i),
    .sample_i (cur_sample),
    .ack_o    (ack_o),
    .rd_dat_o (rd_dat_o)
  );

  AST_EQUAL_NO_SET: assert property (@(posedge clk_i) disable iff (rst_i)
    (!irq_req_o && (cur_sample == prev_sample)) |=> !irq_req_o);  // R5

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    rst_i |=> (!irq_req_o && (rd_dat_o == '0)));  // R1

endmodule

// File: tb/sensor_change_irq_tb_top.sv
`timescale 1ns/1ps
module sensor_change_irq_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       cyc, stb, we;
  logic [7:0] wr_dat;
  logic       ack;
  logic [7:0] rd_dat;
  logic [7:0] sense;
  logic       irq_ack;
  logic       irq_req;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sensor_change_irq #(.SENSE_W(8)) dut_i (
    .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .wr_dat_i(wr_dat), .ack_o(ack), .rd_dat_o(rd_dat), .sense_i(sense),
    .irq_ack_i(irq_ack), .irq_req_o(irq_req)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=60000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_req();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  initial begin
    logic [7:0] last;
    logic [7:0] nv;
    rst = 1'b1; cyc = 0; stb = 0; we = 0; wr_dat = 0; irq_ack = 0;
    sense = 8'hA5;  // held non-zero through reset (R9)
    tick(); tick(); tick();
    chk("R1 reset rd_dat", rd_dat, 0);
    chk("R1 reset irq", irq_req, 0);
    rst = 1'b0;
    tick();
    chk("R2 first sample", rd_dat, 8'hA5);
    chk("R1 irq after release", irq_req, 0);
    tick(); tick(); tick();
    chk("R9 no request after reset", irq_req, 0);
    chk("R2 steady sample", rd_dat, 8'hA5);

    // R3 bus acknowledge
    cyc = 1; stb = 0; #1; chk("R3 ack cyc only", ack, 0);
    cyc = 0; stb = 1; #1; chk("R3 ack stb only", ack, 0);
    cyc = 1; stb = 1; #1; chk("R3 ack both", ack, 1);
    cyc = 0; stb = 0; #1; chk("R3 ack idle", ack, 0);

    // R4 writes ignored
    cyc = 1; stb = 1; we = 1; wr_dat = 8'h5A;
    tick(); tick(); tick();
    chk("R4 write rd_dat", rd_dat, 8'hA5);
    chk("R4 write irq", irq_req, 0);
    cyc = 0; stb = 0; we = 0; wr_dat = 0;
    tick();

    // R5/R2/R7 sweep over a permutation of all values
    last = 8'hA5;
    for (int i = 0; i < 256; i++) begin
      nv = 8'((i * 13 + 7) % 256);
      sense = nv;
      tick();
      chk("R2 sweep sample", rd_dat, nv);
      chk("R5 sweep not yet", irq_req, 0);
      tick();
      chk("R5 sweep set", irq_req, (nv != last) ? 1 : 0);
      if (irq_req) begin
        clear_req();
        chk("R7 sweep ack clears", irq_req, 0);
      end
      last = nv;
    end

    // R5 unchanged value
    tick(); tick(); tick();
    chk("R5 unchanged no set", irq_req, 0);

    // R10 single-bit flips
    for (int b = 0; b < 8; b++) begin
      nv = last ^ (8'h01 << b);
      sense = nv;
      tick(); tick();
      chk("R10 single bit flip", irq_req, 1);
      clear_req();
      chk("R7 flip ack", irq_req, 0);
      last = nv;
    end

    // R6 sticky
    sense = last ^ 8'hFF; last = sense;
    tick(); tick();
    chk("R6 set", irq_req, 1);
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R6 held steady", irq_req, 1);
    end
    sense = last ^ 8'h3C; last = sense;
    tick(); tick(); tick();
    chk("R6 held through second change", irq_req, 1);
    clear_req();
    chk("R7 single clear", irq_req, 0);

    // R8 change and ack in the same cycle
    sense = last ^ 8'h81; last = sense;
    tick();            // change now pending
    irq_ack = 1'b1;
    tick();            // change and ack meet at this edge
    chk("R8 set wins", irq_req, 1);
    tick();
    chk("R7 ack after collision", irq_req, 0);
    irq_ack = 1'b0;
    tick();
    chk("R7 stays clear", irq_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule